// File: doc/BRIEF.md
# Signed Packed-Decimal Digit Shifter

This block moves the digit field of a 128-bit signed packed-decimal number left or right by a whole number of decimal digits. The number carries 31 digits of four bits each, from nibble 31 (the most significant) down to nibble 1, with a sign code in nibble 0. The sign code is kept out of the move. After the move, a normalised sign code is written back into nibble 0.

The shift count is a signed byte taken from a fixed position in a second 128-bit operand. The unit also returns a 4-bit condition field. This field reports an invalid operand, the result's relation to zero, and whether a left shift dropped nonzero digits. All outputs are registered, so a result appears one clock after its operands.

A datapath that executes decimal instructions uses this block as one of its functional units. It drives operands every cycle and takes the registered result on the next cycle.

Top module: `bcd_shift_unit`

## Requirements
- R1: An operand is valid when each of nibbles 1 to 31 holds 0x0–0x9 and nibble 0 holds 0xA–0xF. For an invalid operand the condition field is exactly 4'b0001, and the result value is unspecified.
- R2: The shift count is the two's-complement byte `cnt_opnd[71:64]`. All other bits of `cnt_opnd` have no effect. A count above zero shifts toward more significant digits. A count of zero or below shifts toward less significant digits.
- R3: On a left shift, if any nonzero digit is moved beyond nibble 31, condition bit 0 (overflow) is set.
- R4: The shift distance is the magnitude of the count, limited to 31 digits in both directions. Counts of +127 and -128 therefore act like +31 and -31.
- R5: The sign nibble is cleared before the move. Each step moves the value by 4 bit positions. Vacated digit positions fill with zero. A count of zero leaves the digits unchanged.
- R6: Result nibble 0 is 0xD when the input sign code is 0xB or 0xD. Otherwise it is 0xC when `pref_alt` is 0 and 0xF when `pref_alt` is 1.
- R7: For a valid operand the condition field is {LT, GT, EQ, SO}, bit 3 down to bit 0. EQ is set when all result digits are zero, whatever the sign. If the digits are not all zero, LT is set for a negative sign and GT for a positive one. SO carries the overflow.
- R8: Result and condition are registered with one clock of latency. Synchronous active-high reset clears both to zero.
- R9: A right shift or a zero count never sets the overflow bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_opnd | input | 128 | Signed packed-decimal operand |
| cnt_opnd | input | 128 | Operand whose bits 71:64 hold the signed digit count |
| pref_alt | input | 1 | Selects 0xF instead of 0xC as the positive sign code |
| res_q | output | 128 | Registered shifted result |
| cond_q | output | 4 | Registered condition field {LT, GT, EQ, SO} |

## Verification
Random valid operands are shifted by random counts across the whole signed byte range, with random data in the unused count bytes. This separates left shifts from right shifts and clamped counts from unclamped ones. It also shows that the count is read from the correct byte.

Operands made mostly of zero digits are tried as well. They test EQ against LT and GT for both sign polarities, and test overflow against a clean left shift when a single high digit is present. Directed vectors cover these cases:
- counts of zero, ±31, +127 and -128;
- a negative zero;
- both states of the sign-select input;
- operands with a bad digit and with a bad sign code, to show that an invalid operand masks every other flag.

// File: rtl/bcd_shift_pkg.sv
package bcd_shift_pkg;

    typedef logic [3:0] nib_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    typedef struct packed {
        logic valid;
        logic neg;
    } opnd_info_t;

    typedef enum logic [3:0] {
        SGN_POS_STD = 4'hC,
        SGN_NEG_STD = 4'hD,
        SGN_POS_ALT = 4'hF
    } sign_code_e;

    function automatic logic nib_is_digit(input nib_t n);
        return n <= 4'h9;
    endfunction

    function automatic logic nib_is_sign(input nib_t n);
        return n >= 4'hA;
    endfunction

    function automatic logic sign_is_neg(input nib_t n);
        return (n == 4'hB) || (n == 4'hD);
    endfunction

    function automatic sign_code_e pick_sign(input logic neg, input logic alt);
        if (neg)      return SGN_NEG_STD;
        else if (alt) return SGN_POS_ALT;
        else          return SGN_POS_STD;
    endfunction

endpackage

// File: rtl/bcd_operand_check.sv
module bcd_operand_check
    import bcd_shift_pkg::*;
#(
    parameter int DIGITS = 31
) (
    input  logic [(DIGITS+1)*4-1:0] opnd,
    output opnd_info_t              info
);
    logic [DIGITS:1] digit_ok;

    for (genvar g = 1; g <= DIGITS; g++) begin : g_digit
        assign digit_ok[g] = nib_is_digit(opnd[g*4 +: 4]);
    end

    always_comb begin
        info.valid = (&digit_ok) && nib_is_sign(opnd[3:0]);
        info.neg   = sign_is_neg(opnd[3:0]);
    end
endmodule

// File: rtl/bcd_digit_shift.sv
module bcd_digit_shift #(
    parameter int DIGITS = 31,
    parameter int CNT_W  = 8
) (
    input  logic [(DIGITS+1)*4-1:0] field,
    input  logic [CNT_W-1:0]        cnt,
    output logic [(DIGITS+1)*4-1:0] shifted,
    output logic                    lost
);
    localparam int W     = (DIGITS + 1) * 4;
    localparam int AMT_W = $clog2(DIGITS + 1);
    localparam logic [CNT_W:0] MAX_MAG = (CNT_W + 1)'(DIGITS);

    logic [CNT_W:0]   ext;
    logic [CNT_W:0]   mag;
    logic [AMT_W-1:0] amt;
    logic             go_left;
    logic [2*W-1:0]   wide;

    always_comb begin
        ext     = {cnt[CNT_W-1], cnt};
        go_left = !ext[CNT_W] && (|ext);
        mag     = ext[CNT_W] ? (~ext + 1'b1) : ext;
        amt     = (mag > MAX_MAG) ? AMT_W'(DIGITS) : mag[AMT_W-1:0];
        wide    = {{W{1'b0}}, field} << {amt, 2'b00};
        if (go_left) begin
            shifted = wide[W-1:0];
            lost    = |wide[2*W-1:W];
        end else begin
            shifted = field >> {amt, 2'b00};
            lost    = 1'b0;
        end
    end
endmodule

// File: rtl/bcd_result_form.sv
module bcd_result_form
    import bcd_shift_pkg::*;
#(
    parameter int DIGITS = 31
) (
    input  logic [DIGITS*4-1:0]     digits,
    input  opnd_info_t              info,
    input  logic                    alt,
    input  logic                    lost,
    output logic [(DIGITS+1)*4-1:0] res,
    output cond_t                   cond
);
    logic all_zero;

    always_comb begin
        all_zero = ~|digits;
        res      = {digits, pick_sign(info.neg, alt)};
        if (!info.valid) begin
            cond = '{lt: 1'b0, gt: 1'b0, eq: 1'b0, so: 1'b1};
        end else begin
            cond.lt = !all_zero && info.neg;
            cond.gt = !all_zero && !info.neg;
            cond.eq = all_zero;
            cond.so = lost;
        end
    end
endmodule

// File: rtl/bcd_shift_unit.sv
module bcd_shift_unit
    import bcd_shift_pkg::*;
#(
    parameter int DIGITS  = 31,
    parameter int CNT_W   = 8,
    parameter int CNT_LSB = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [(DIGITS+1)*4-1:0] dec_opnd,
    input  logic [(DIGITS+1)*4-1:0] cnt_opnd,
    input  logic                    pref_alt,
    output logic [(DIGITS+1)*4-1:0] res_q,
    output logic [3:0]              cond_q
);
    localparam int W = (DIGITS + 1) * 4;

    opnd_info_t    info;
    logic [W-1:0]  field;
    logic [W-1:0]  shifted;
    logic          lost;
    logic [W-1:0]  res_d;
    cond_t         cond_d;

    assign field = {dec_opnd[W-1:4], 4'h0};

    bcd_operand_check #(.DIGITS(DIGITS)) chk_u (
        .opnd (dec_opnd),
        .info (info)
    );

    bcd_digit_shift #(.DIGITS(DIGITS), .CNT_W(CNT_W)) shf_u (
        .field   (field),
        .cnt     (cnt_opnd[CNT_LSB +: CNT_W]),
        .shifted (shifted),
        .lost    (lost)
    );

    bcd_result_form #(.DIGITS(DIGITS)) frm_u (
        .digits (shifted[W-1:4]),
        .info   (info),
        .alt    (pref_alt),
        .lost   (lost),
        .res    (res_d),
        .cond   (cond_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            cond_q <= '0;
        end else begin
            res_q  <= res_d;
            cond_q <= cond_d;
        end
    end
endmodule

// File: rtl/bcd_shift_unit_chk.sv
module bcd_shift_unit_chk #(
    parameter int DIGITS  = 31,
    parameter int CNT_W   = 8,
    parameter int CNT_LSB = 64
) (
    input logic                    clk,
    input logic                    rst,
    input logic [(DIGITS+1)*4-1:0] dec_opnd,
    input logic [(DIGITS+1)*4-1:0] cnt_opnd,
    input logic                    pref_alt,
    input logic [(DIGITS+1)*4-1:0] res_q,
    input logic [3:0]              cond_q
);
    localparam int W = (DIGITS + 1) * 4;

    logic seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (res_q == '0 && cond_q == 4'b0000));

    assert_single_relation_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(cond_q[3:1]) <= 1);

    assert_invalid_so_only_R1: assert property (@(posedge clk) disable iff (rst)
        (seen_q && cond_q[3:1] == 3'b000) |-> (cond_q == 4'b0001));

    assert_eq_digits_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (seen_q && cond_q[1]) |-> (res_q[W-1:4] == '0));

    assert_sign_code_R6: assert property (@(posedge clk) disable iff (rst)
        (seen_q && cond_q[3:1] != 3'b000) |->
            (res_q[3:0] == 4'hC || res_q[3:0] == 4'hD || res_q[3:0] == 4'hF));

    assert_lt_neg_code_R6: assert property (@(posedge clk) disable iff (rst)
        (seen_q && cond_q[3]) |-> (res_q[3:0] == 4'hD));

    assert_alt_pos_code_R6: assert property (@(posedge clk) disable iff (rst)
        (seen_q && cond_q[2] && $past(pref_alt)) |-> (res_q[3:0] == 4'hF));

    assert_no_overflow_right_R9: assert property (@(posedge clk) disable iff (rst)
        ($signed(cnt_opnd[CNT_LSB +: CNT_W]) <= 0) |=>
            (cond_q[3:1] == 3'b000 || !cond_q[0]));

    assert_zero_count_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_opnd[CNT_LSB +: CNT_W] == '0) |=>
            (cond_q[3:1] == 3'b000 || res_q[W-1:4] == $past(dec_opnd[W-1:4])));
endmodule

bind bcd_shift_unit bcd_shift_unit_chk #(
    .DIGITS(DIGITS), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)
) sva_i (
    .clk(clk), .rst(rst), .dec_opnd(dec_opnd), .cnt_opnd(cnt_opnd),
    .pref_alt(pref_alt), .res_q(res_q), .cond_q(cond_q)
);

// File: tb/bcd_shift_unit_tb_top.sv
module bcd_shift_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] dec_opnd = '0;
    logic [127:0] cnt_opnd = '0;
    logic         pref_alt = 1'b0;
    logic [127:0] res_q;
    logic [3:0]   cond_q;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    bcd_shift_unit dut_i (
        .clk(clk), .rst(rst), .dec_opnd(dec_opnd), .cnt_opnd(cnt_opnd),
        .pref_alt(pref_alt), .res_q(res_q), .cond_q(cond_q)
    );

    function automatic void ref_model(input logic [127:0] d, input logic [7:0] c,
                                      input logic alt, output logic [127:0] r,
                                      output logic [3:0] cf, output logic ok);
        int          k;
        bit          left;
        bit          ov;
        bit          neg;
        bit          z;
        logic [3:0]  dig [32];
        logic [3:0]  nd  [32];
        ok = 1'b1;
        for (int i = 1; i < 32; i++) if (d[i*4 +: 4] > 4'h9) ok = 1'b0;
        if (d[3:0] < 4'hA) ok = 1'b0;
        k = int'($signed(c));
        left = (k > 0);
        if (k < 0) k = -k;
        if (k > 31) k = 31;
        dig[0] = 4'h0;
        for (int i = 1; i < 32; i++) dig[i] = d[i*4 +: 4];
        ov = 1'b0;
        z = 1'b1;
        for (int i = 1; i < 32; i++) begin
            int src;
            src = left ? (i - k) : (i + k);
            nd[i] = (src >= 1 && src <= 31) ? dig[src] : 4'h0;
            if (nd[i] != 4'h0) z = 1'b0;
            if (left && (i + k > 31) && dig[i] != 4'h0) ov = 1'b1;
        end
        neg = (d[3:0] == 4'hB) || (d[3:0] == 4'hD);
        r[3:0] = neg ? 4'hD : (alt ? 4'hF : 4'hC);
        for (int i = 1; i < 32; i++) r[i*4 +: 4] = nd[i];
        if (!ok) cf = 4'b0001;
        else     cf = {!z && neg, !z && !neg, z, ov};
    endfunction

    task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [127:0] d, input logic [7:0] c, input logic alt,
                           input string tag);
        logic [127:0] er;
        logic [3:0]   ec;
        logic         ok;
        ref_model(d, c, alt, er, ec, ok);
        @(negedge clk);
        dec_opnd = d;
        cnt_opnd = {$urandom(), $urandom(), $urandom(), $urandom()};
        cnt_opnd[71:64] = c;
        pref_alt = alt;
        @(negedge clk);
        check({124'b0, cond_q}, {124'b0, ec}, {tag, " cond"});
        if (ok) check(res_q, er, {tag, " result"});
    endtask

    function automatic logic [127:0] rand_opnd(input int mode);
        logic [127:0] v;
        for (int i = 1; i < 32; i++) begin
            if (mode == 1 && $urandom_range(0, 7) != 0) v[i*4 +: 4] = 4'h0;
            else v[i*4 +: 4] = 4'($urandom_range(0, 9));
        end
        v[3:0] = 4'($urandom_range(10, 15));
        if (mode == 2) begin
            if ($urandom_range(0, 1) == 1) v[3:0] = 4'($urandom_range(0, 9));
            else v[$urandom_range(1, 31)*4 +: 4] = 4'($urandom_range(10, 15));
        end
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(res_q, 128'h0, "R8 reset result");
        check({124'b0, cond_q}, 128'h0, "R8 reset cond");
        @(negedge clk);
        rst = 1'b0;

        run_vec(128'h0000_0000_0000_0000_0000_0000_0012_345C, 8'd2,   1'b0, "R2 R5 left 2");
        run_vec(128'h0000_0000_0000_0000_0000_0000_0012_345D, 8'hFE, 1'b0, "R2 R7 right 2 neg");
        run_vec(128'h0000_0000_0000_0000_0000_0000_0012_345A, 8'd0,   1'b1, "R5 R6 zero count alt");
        run_vec(128'h9000_0000_0000_0000_0000_0000_0000_000C, 8'd1,   1'b0, "R3 overflow to zero");
        run_vec(128'h0900_0000_0000_0000_0000_0000_0000_001C, 8'd1,   1'b0, "R3 no loss");
        run_vec(128'h9000_0000_0000_0000_0000_0000_0000_000C, 8'hFF, 1'b0, "R9 right no overflow");
        run_vec(128'h1234_5678_9012_3456_7890_1234_5678_901B, 8'd127, 1'b0, "R4 clamp +127");
        run_vec(128'h1234_5678_9012_3456_7890_1234_5678_901B, 8'd31,  1'b0, "R4 +31");
        run_vec(128'h1234_5678_9012_3456_7890_1234_5678_901F, 8'h80, 1'b1, "R4 clamp -128");
        run_vec(128'h1234_5678_9012_3456_7890_1234_5678_901F, 8'hE1, 1'b1, "R4 -31");
        run_vec(128'h1000_0000_0000_0000_0000_0000_0000_000E, 8'd30,  1'b1, "R4 R3 +30 loss");
        run_vec(128'h0000_0000_0000_0000_0000_0000_0000_000D, 8'd3,   1'b0, "R7 negative zero");
        run_vec(128'h0000_0000_0000_0000_0000_0000_0012_3A0C, 8'd1,   1'b0, "R1 bad digit");
        run_vec(128'h0000_0000_0000_0000_0000_0000_0012_3455, 8'd0,   1'b0, "R1 bad sign");
        run_vec(128'h9000_0000_0000_0000_0000_0000_00A0_000C, 8'd5,   1'b0, "R1 bad digit masks SO");
        run_vec(128'h0000_0000_0000_0000_0000_0000_0000_077B, 8'd1,   1'b1, "R6 sign B to D");

        for (int n = 0; n < 600; n++) begin
            int mode;
            mode = (n % 10 == 9) ? 2 : ((n % 3 == 0) ? 1 : 0);
            run_vec(rand_opnd(mode), 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                    "R2 R3 R4 R5 R6 R7 random");
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(res_q, 128'h0, "R8 mid-run reset result");
        check({124'b0, cond_q}, 128'h0, "R8 mid-run reset cond");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule